// File: doc/BRIEF.md
# Power-On Reset Pulse Generator

This block turns a digital supply-good flag into a clean internal reset pulse. The flag comes from an analog comparator and reads high while the core rail is above its trip level. The flag is asynchronous to the block clock, so it first passes through a synchronizer. A rise of the flag that is allowed to trigger starts a reset pulse of fixed length, counted in clock cycles.

The first rise after reset is always allowed to trigger. After that, a new pulse is allowed only when the rail has first fallen away for long enough. A low stretch shorter than the qualifying width is treated as noise and is ignored. A qualifying low stretch is remembered, so the next rise of the flag starts a new pulse even if that rise comes much later.

If the rail recovers from a qualifying dip while a pulse is already running, the pulse is extended: the full pulse length is counted again from the new start. A dip never cuts a running pulse short.

Top module: `por_pulse_gen`

## Requirements
- R1: `por_o` is low while `rst_n` is low, and it stays low after reset until `supply_ok_i` is first seen high.
- R2: The first rise of `supply_ok_i` after reset drives `por_o` high. Let edge E be the first clock edge that samples the input high. `por_o` goes high at edge E+2, which accounts for two synchronizer stages and one output register.
- R3: Once started, `por_o` stays high for exactly PULSE_CYCLES clock cycles and then returns low.
- R4: A low period of MIN_LOW_CYCLES or more consecutive samples is a qualifying dip. After a qualifying dip, the next rise of `supply_ok_i` starts a new pulse with the same latency as in R2.
- R5: A low period shorter than MIN_LOW_CYCLES samples is ignored. No pulse follows it, and `por_o` stays low. This also holds for trains of such short dips.
- R6: If a qualifying dip ends while a pulse is running, the pulse is not shortened. `por_o` stays high until PULSE_CYCLES cycles after the restart.
- R7: A short dip during a running pulse leaves that pulse at exactly its original length.
- R8: Holding `supply_ok_i` high for any length of time produces only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| supply_ok_i | input | 1 | Asynchronous supply-good flag from the comparator |
| por_o | output | 1 | Internal power-on reset pulse, active high |

## Verification
A dip qualifier that counts wrongly changes whether a pulse appears after the rail recovers. This shows at `por_o` two cycles after the recovery edge, when the pulse is either missing or present. A latch that fails to clear shows as a second pulse on a later short dip or under a long high input. A wrong stretch count shows as a falling edge of `por_o` that is early or late by a whole number of cycles. Dip lengths are swept across the qualifying boundary, including dips that land inside a running pulse, so each of these faults appears within one pulse length of its cause.

// File: rtl/por_pkg.sv
package por_pkg;
  // Width needed to hold values 0 .. n-1 (never less than one bit).
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  output logic rst_sync_n,
  output logic flag_o
);
  logic [STAGES-1:0] rst_sh_q, rst_sh_d;
  logic [STAGES-1:0] flag_sh_q, flag_sh_d;

  always_comb begin
    rst_sh_d  = {rst_sh_q[STAGES-2:0], 1'b1};
    flag_sh_d = {flag_sh_q[STAGES-2:0], supply_ok_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q  <= '0;
      flag_sh_q <= '0;
    end else begin
      rst_sh_q  <= rst_sh_d;
      flag_sh_q <= flag_sh_d;
    end
  end

  assign rst_sync_n = rst_sh_q[STAGES-1];
  assign flag_o     = flag_sh_q[STAGES-1];

  // R2: each synchronizer stage carries the previous stage one cycle later
  for (genvar i = 1; i < STAGES; i++) begin : g_chk
    a_r2_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
      flag_sh_q[i] == $past(flag_sh_q[i-1]));
  end
endmodule

// File: rtl/por_dip_filter.sv
module por_dip_filter
  import por_pkg::*;
#(
  parameter int MIN_LOW_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic start_i,
  output logic armed_o
);
  localparam int LW = cnt_w(MIN_LOW_CYCLES + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW_CYCLES);
  localparam logic [LW-1:0] LOW_ARM = LW'(MIN_LOW_CYCLES - 1);

  logic [LW-1:0] low_q, low_d;
  logic          low_en;
  logic          armed_q, armed_d;

  always_comb begin
    low_en  = flag_i ? (low_q != '0) : (low_q != LOW_MAX);
    low_d   = flag_i ? '0 : low_q + 1'b1;
    armed_d = armed_q;
    if (!flag_i && (low_q == LOW_ARM)) armed_d = 1'b1;
    if (start_i) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (low_en) low_q <= low_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  // R4: the qualifier can only become set while the flag is low
  a_r4_arm_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> !$past(flag_i));
  // R8: a rise that triggers consumes the qualifier
  a_r8_consume: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !armed_q);
  // R5: a high flag restarts low-width counting from zero
  a_r5_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_i |=> (low_q == '0));
endmodule

// File: rtl/por_stretch.sv
module por_stretch
  import por_pkg::*;
#(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int PW = cnt_w(PULSE_CYCLES);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || busy_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_i) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  // R3, R6: a pulse with cycles left is never cut short
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != '0)) |=> busy_q);
  // R3: the pulse ends when its count runs out and no restart arrives
  a_r3_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q == '0) && !start_i) |=> !busy_q);
  // R5: with no start request, an idle stretcher stays idle
  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/por_pulse_gen.sv
module por_pulse_gen #(
  parameter int SYNC_STAGES    = 2,
  parameter int PULSE_CYCLES   = 8,
  parameter int MIN_LOW_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  output logic por_o
);
  logic rst_sync_n;
  logic flag_s;
  logic armed;
  logic start;

  por_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok_i),
    .rst_sync_n  (rst_sync_n),
    .flag_o      (flag_s)
  );

  assign start = flag_s && armed;

  por_dip_filter #(.MIN_LOW_CYCLES(MIN_LOW_CYCLES)) i_dip (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flag_i  (flag_s),
    .start_i (start),
    .armed_o (armed)
  );

  por_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) i_stretch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start),
    .busy_o  (por_o)
  );

  // R1: reset forces the output low
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> !por_o);
  // R2: a triggering rise shows at the output on the next edge
  a_r2_start_out: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> por_o);
endmodule

// File: tb/test_por_pulse_gen.sv
module test_por_pulse_gen;
  localparam int PULSE   = 8;
  localparam int MIN_LOW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok;
  logic por;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  bit  armed_m;
  bit  prev_m;
  int  lowrun;
  int  step_no;
  int  w0_lo, w0_hi, w1_lo, w1_hi;

  always #4 clk = ~clk;

  por_pulse_gen #(
    .SYNC_STAGES    (2),
    .PULSE_CYCLES   (PULSE),
    .MIN_LOW_CYCLES (MIN_LOW)
  ) i_por_pulse_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok),
    .por_o       (por)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step %0d: por_o=%b expected %b", tag, step_no, act, exp);
    end
  endtask

  task automatic model_clear();
    armed_m = 1'b1;
    prev_m  = 1'b0;
    lowrun  = 0;
    step_no = 0;
    w0_lo = -100; w0_hi = -101;
    w1_lo = -100; w1_hi = -101;
  endtask

  // Called at a falling edge: drive one input sample, pass one rising edge, check.
  task automatic step(input logic v, input string tag);
    logic exp;
    supply_ok = v;
    if (v) begin
      if (!prev_m && armed_m) begin
        w0_lo = w1_lo; w0_hi = w1_hi;
        w1_lo = step_no + 2;
        w1_hi = step_no + 1 + PULSE;
        armed_m = 1'b0;
      end
      lowrun = 0;
    end else begin
      lowrun++;
      if (lowrun >= MIN_LOW) armed_m = 1'b1;
    end
    prev_m = v;
    @(negedge clk);
    exp = ((step_no >= w0_lo) && (step_no <= w0_hi)) ||
          ((step_no >= w1_lo) && (step_no <= w1_hi));
    check(tag, por, exp);
    step_no++;
  endtask

  task automatic run(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) step(v, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", por, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", por, 1'b0);
    end
    model_clear();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    rst_n = 1'b0;
    supply_ok = 1'b0;
    model_clear();
    @(negedge clk);
    do_reset();

    // R1: low input after reset gives no pulse; R2, R3: first rise
    run(1'b0, 3, "R1");
    run(1'b1, PULSE + 4, "R2 R3");

    // R4 / R5: sweep the dip length across the qualifying boundary
    for (int n = 1; n <= MIN_LOW + 2; n++) begin
      run(1'b0, n, (n >= MIN_LOW) ? "R4" : "R5");
      run(1'b1, PULSE + 4, (n >= MIN_LOW) ? "R4 R3" : "R5");
    end

    // R8: a long steady high produces nothing more
    run(1'b1, 30, "R8");

    // R5: train of short dips
    for (int i = 0; i < 6; i++) begin
      run(1'b0, MIN_LOW - 2, "R5");
      run(1'b1, 1, "R5");
    end
    run(1'b1, PULSE, "R5");

    // R6: qualifying dip inside a running pulse extends it
    run(1'b0, MIN_LOW, "R6");
    run(1'b1, 3, "R6");
    run(1'b0, MIN_LOW, "R6");
    run(1'b1, PULSE + 6, "R6");

    // R7: short dip inside a running pulse leaves its length alone
    run(1'b0, MIN_LOW, "R7");
    run(1'b1, 3, "R7");
    run(1'b0, MIN_LOW - 2, "R7");
    run(1'b1, PULSE + 4, "R7");

    // R1: reset during a pulse clears the output, then the first rise triggers again
    run(1'b0, MIN_LOW, "R4");
    run(1'b1, 4, "R4");
    rst_n = 1'b0;
    #1;
    check("R1", por, 1'b0);
    @(negedge clk);
    do_reset();
    run(1'b0, 2, "R1");
    run(1'b1, PULSE + 4, "R2 R3");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule